// File: doc/BRIEF.md
# Virtualized CPU Identity Register and Access Router

This block keeps a 64-bit identity value that a hypervisor can program, and settles every system-register access aimed either at that copy or at the real processor identity. A request carries a target select, a read/write flag, the privilege level of the requester (0 to 3) and write data. The block weighs the level against a set of configuration inputs. These inputs are: whether a hypervisor level exists and is enabled, a 3-bit nested-virtualization control, fine-grained trap controls, an identity-trap feature flag and a general trap-routing bit. The result is one of six outcomes, and the block reports it one cycle later.

When a guest kernel reads the real identity, it sees the hypervisor-programmed copy whenever the hypervisor is enabled. Accesses to the copy itself can go four ways: they are served directly, sent to a memory access at a fixed offset, trapped to the hypervisor with a syndrome class, or faulted as undefined. The block reports a memory redirect or an exception but does not carry it out.

The response path is a two-state machine. `ST_IDLE` moves to `ST_RESP` on the transition *accept* (a request is present). `ST_RESP` stays in `ST_RESP` on *accept* and returns to `ST_IDLE` on *drain* (no request). The response valid strobe is high exactly while the machine is in `ST_RESP`.

Top module: `vid_access`

## Requirements
- R1: After reset, `rsp_valid` is 0. The stored copy holds `real_id` with bits 63:32 forced to zero.
- R2: A request accepted at a clock edge produces `rsp_valid`=1 for the following cycle only. `rsp_outcome` is one-hot with bit0 data returned, bit1 write performed, bit2 write ignored, bit3 undefined fault, bit4 trap, bit5 memory redirect. It is all-zero when `rsp_valid` is 0.
- R3: Any access to the copy (`req_sel`=1) at level 0 gives the undefined outcome.
- R4: At level 1, an access to the copy with `nv_ctrl[2]`=1 and `nv_ctrl[0]`=1 gives the redirect outcome with `rsp_mem_offset`=0x088 and data 0. It leaves the copy unchanged.
- R5: At level 1, an access to the copy with `nv_ctrl[0]`=1 and `nv_ctrl[2]`=0 traps to level 2 with syndrome 0x18. With `nv_ctrl[0]`=0 it is undefined.
- R6: At level 2, a read of the copy returns it and a write stores the low 32 bits with bits 63:32 zero. A read in the next request sees the new value.
- R7: At level 3 with `hyp_present`=0, a read of the copy returns `real_id` and a write gives the write-ignored outcome with the copy unchanged. With `hyp_present`=1, level 3 behaves as level 2.
- R8: A level-1 read of the real identity (`req_sel`=0) traps to level 2 with syndrome 0x18 when all of these hold: `hyp_enabled`, `fgt_impl`, `fgt_id_rd`, and either `top_present`=0 or `top_fgt_en`=1.
- R9: A level-1 read of the real identity that does not trap returns the copy when `hyp_enabled`=1, and `real_id` otherwise.
- R10: A level-0 read of the real identity is undefined when `id_trap_feat`=0. Otherwise it traps with syndrome 0x18, to level 2 if `hyp_enabled` and `tge` are both 1, else to level 1.
- R11: Reads of the real identity at levels 2 and 3 return `real_id`. Any write to the real identity is undefined.
- R12: Outside the trap outcome `rsp_trap_level` and `rsp_syndrome` are 0. Outside the redirect outcome `rsp_mem_offset` is 0. Outside the data outcome `rsp_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_sel | input | 1 | 1 = hypervisor copy, 0 = real identity |
| req_write | input | 1 | 1 = write, 0 = read |
| req_level | input | 2 | Privilege level of the requester |
| req_wdata | input | 64 | Write data |
| hyp_present | input | 1 | Hypervisor level implemented |
| hyp_enabled | input | 1 | Hypervisor level enabled in current state |
| nv_ctrl | input | 3 | Nested-virtualization control |
| fgt_impl | input | 1 | Fine-grained traps implemented |
| top_present | input | 1 | Highest privilege level implemented |
| top_fgt_en | input | 1 | Fine-grained trap enable from highest level |
| fgt_id_rd | input | 1 | Per-register read trap bit for the real identity |
| id_trap_feat | input | 1 | Level-0 identity reads trap instead of faulting |
| tge | input | 1 | Route level-0 traps to the hypervisor |
| real_id | input | 64 | Constant real identity value |
| rsp_valid | output | 1 | Response strobe |
| rsp_outcome | output | 6 | One-hot outcome |
| rsp_data | output | 64 | Read data |
| rsp_trap_level | output | 2 | Target level of a trap |
| rsp_syndrome | output | 6 | Trap syndrome class |
| rsp_mem_offset | output | 12 | Redirect offset |

## Verification
The assertions assume that `real_id` does not change after reset. They also assume a consistent configuration: `hyp_enabled` is never 1 without `hyp_present`, and no level-2 request arrives while the hypervisor level is absent. The bench sweeps only configurations that keep these rules. It walks three legal presence/enable pairs, skips level 2 when the hypervisor is absent, and ties `real_id` to a fixed value. Every other input combination is covered exhaustively.

// File: rtl/vid_pkg.sv
package vid_pkg;

    typedef enum logic [5:0] {
        OC_NONE  = 6'b000000,
        OC_DATA  = 6'b000001,
        OC_WDONE = 6'b000010,
        OC_WIGN  = 6'b000100,
        OC_UNDEF = 6'b001000,
        OC_TRAP  = 6'b010000,
        OC_MEM   = 6'b100000
    } outcome_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } rsp_state_e;

    typedef struct packed {
        outcome_e   oc;
        logic       rd_virt;
        logic       rd_real;
        logic       wr_virt;
        logic [1:0] trap_lvl;
    } route_t;

endpackage

// File: rtl/vid_route.sv
module vid_route
    import vid_pkg::*;
(
    input  logic       req_sel,
    input  logic       req_write,
    input  logic [1:0] req_level,
    input  logic       hyp_present,
    input  logic       hyp_enabled,
    input  logic [2:0] nv_ctrl,
    input  logic       fgt_impl,
    input  logic       top_present,
    input  logic       top_fgt_en,
    input  logic       fgt_id_rd,
    input  logic       id_trap_feat,
    input  logic       tge,
    output route_t     route_o
);

    logic fgt_hit;
    logic nv_redirect;
    logic nv_trap;

    assign fgt_hit     = hyp_enabled && fgt_impl && fgt_id_rd && (!top_present || top_fgt_en);
    assign nv_redirect = nv_ctrl[0] && nv_ctrl[2];
    assign nv_trap     = nv_ctrl[0] && !nv_ctrl[2];

    always_comb begin
        route_o.oc       = OC_UNDEF;
        route_o.rd_virt  = 1'b0;
        route_o.rd_real  = 1'b0;
        route_o.wr_virt  = 1'b0;
        route_o.trap_lvl = 2'd0;
        if (req_sel) begin
            unique case (req_level)
                2'd0: route_o.oc = OC_UNDEF;
                2'd1: begin
                    if (nv_redirect) begin
                        route_o.oc = OC_MEM;
                    end else if (nv_trap) begin
                        route_o.oc       = OC_TRAP;
                        route_o.trap_lvl = 2'd2;
                    end else begin
                        route_o.oc = OC_UNDEF;
                    end
                end
                2'd2, 2'd3: begin
                    if (req_level == 2'd3 && !hyp_present) begin
                        if (req_write) begin
                            route_o.oc = OC_WIGN;
                        end else begin
                            route_o.oc      = OC_DATA;
                            route_o.rd_real = 1'b1;
                        end
                    end else if (req_write) begin
                        route_o.oc      = OC_WDONE;
                        route_o.wr_virt = 1'b1;
                    end else begin
                        route_o.oc      = OC_DATA;
                        route_o.rd_virt = 1'b1;
                    end
                end
                default: route_o.oc = OC_UNDEF;
            endcase
        end else if (req_write) begin
            route_o.oc = OC_UNDEF;
        end else begin
            unique case (req_level)
                2'd0: begin
                    if (id_trap_feat) begin
                        route_o.oc       = OC_TRAP;
                        route_o.trap_lvl = (hyp_enabled && tge) ? 2'd2 : 2'd1;
                    end else begin
                        route_o.oc = OC_UNDEF;
                    end
                end
                2'd1: begin
                    if (fgt_hit) begin
                        route_o.oc       = OC_TRAP;
                        route_o.trap_lvl = 2'd2;
                    end else if (hyp_enabled) begin
                        route_o.oc      = OC_DATA;
                        route_o.rd_virt = 1'b1;
                    end else begin
                        route_o.oc      = OC_DATA;
                        route_o.rd_real = 1'b1;
                    end
                end
                2'd2, 2'd3: begin
                    route_o.oc      = OC_DATA;
                    route_o.rd_real = 1'b1;
                end
                default: route_o.oc = OC_UNDEF;
            endcase
        end
    end

endmodule

// File: rtl/vid_store.sv
module vid_store #(
    parameter int DATA_W = 64,
    parameter int ID_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] real_id,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] vreg_o
);

    localparam int RSV_W = DATA_W - ID_W;
    localparam logic [DATA_W-1:0] KEEP_MASK = {{RSV_W{1'b0}}, {ID_W{1'b1}}};

    logic [DATA_W-1:0] vreg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vreg_q <= real_id & KEEP_MASK;
        end else if (wr_en) begin
            vreg_q <= wr_data & KEEP_MASK;
        end
    end

    assign vreg_o = vreg_q;

    // R7
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(vreg_q));

endmodule

// File: rtl/vid_access.sv
module vid_access
    import vid_pkg::*;
#(
    parameter int          DATA_W  = 64,
    parameter int          ID_W    = 32,
    parameter int          OFS_W   = 12,
    parameter int          EC_W    = 6,
    parameter logic [11:0] MEM_OFS = 12'h088,
    parameter logic [5:0]  TRAP_EC = 6'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_sel,
    input  logic              req_write,
    input  logic [1:0]        req_level,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              hyp_present,
    input  logic              hyp_enabled,
    input  logic [2:0]        nv_ctrl,
    input  logic              fgt_impl,
    input  logic              top_present,
    input  logic              top_fgt_en,
    input  logic              fgt_id_rd,
    input  logic              id_trap_feat,
    input  logic              tge,
    input  logic [DATA_W-1:0] real_id,
    output logic              rsp_valid,
    output logic [5:0]        rsp_outcome,
    output logic [DATA_W-1:0] rsp_data,
    output logic [1:0]        rsp_trap_level,
    output logic [EC_W-1:0]   rsp_syndrome,
    output logic [OFS_W-1:0]  rsp_mem_offset
);

    route_t            route;
    logic [DATA_W-1:0] vreg;
    logic [DATA_W-1:0] rd_value;
    rsp_state_e        st_q, st_d;

    vid_route u_route (
        .req_sel      (req_sel),
        .req_write    (req_write),
        .req_level    (req_level),
        .hyp_present  (hyp_present),
        .hyp_enabled  (hyp_enabled),
        .nv_ctrl      (nv_ctrl),
        .fgt_impl     (fgt_impl),
        .top_present  (top_present),
        .top_fgt_en   (top_fgt_en),
        .fgt_id_rd    (fgt_id_rd),
        .id_trap_feat (id_trap_feat),
        .tge          (tge),
        .route_o      (route)
    );

    vid_store #(
        .DATA_W (DATA_W),
        .ID_W   (ID_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .real_id (real_id),
        .wr_en   (req_valid && route.wr_virt),
        .wr_data (req_wdata),
        .vreg_o  (vreg)
    );

    always_comb begin
        rd_value = '0;
        if (route.rd_virt) begin
            rd_value = vreg;
        end else if (route.rd_real) begin
            rd_value = real_id;
        end
    end

    // Next-state decode: accept / drain
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: st_d = req_valid ? ST_RESP : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Registered response fields
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_outcome    <= OC_NONE;
            rsp_data       <= '0;
            rsp_trap_level <= 2'd0;
            rsp_syndrome   <= '0;
            rsp_mem_offset <= '0;
        end else begin
            rsp_outcome    <= route.oc;
            rsp_data       <= (route.oc == OC_DATA) ? rd_value : '0;
            rsp_trap_level <= route.trap_lvl;
            rsp_syndrome   <= (route.oc == OC_TRAP) ? TRAP_EC : '0;
            rsp_mem_offset <= (route.oc == OC_MEM) ? MEM_OFS : '0;
        end
    end

    assign rsp_valid = (st_q == ST_RESP);

    // R2
    rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones(rsp_outcome) == 1));

    // R2
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_outcome == 6'b0));

    // R3
    virt_lvl0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_sel && req_level == 2'd0) |=> (rsp_outcome == OC_UNDEF));

    // R5
    trap_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_outcome == OC_TRAP) |-> (rsp_syndrome == TRAP_EC && rsp_trap_level != 2'd0));

    // R4
    redirect_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && route.oc == OC_MEM) |=> ($stable(vreg) && rsp_mem_offset == MEM_OFS));

    // R7
    ignore_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && route.oc == OC_WIGN) |=> $stable(vreg));

    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vreg[DATA_W-1:ID_W] == '0);

endmodule

// File: tb/vid_access_bench.sv
module vid_access_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] REAL_VAL = 64'h0000_0001_5A2F_C3E7;

    localparam logic [5:0] E_DATA  = 6'b000001;
    localparam logic [5:0] E_WDONE = 6'b000010;
    localparam logic [5:0] E_WIGN  = 6'b000100;
    localparam logic [5:0] E_UNDEF = 6'b001000;
    localparam logic [5:0] E_TRAP  = 6'b010000;
    localparam logic [5:0] E_MEM   = 6'b100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_sel = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_level = 2'd0;
    logic [63:0] req_wdata = '0;
    logic        hyp_present = 1'b0;
    logic        hyp_enabled = 1'b0;
    logic [2:0]  nv_ctrl = 3'd0;
    logic        fgt_impl = 1'b0;
    logic        top_present = 1'b0;
    logic        top_fgt_en = 1'b0;
    logic        fgt_id_rd = 1'b0;
    logic        id_trap_feat = 1'b0;
    logic        tge = 1'b0;
    logic        rsp_valid;
    logic [5:0]  rsp_outcome;
    logic [63:0] rsp_data;
    logic [1:0]  rsp_trap_level;
    logic [5:0]  rsp_syndrome;
    logic [11:0] rsp_mem_offset;

    int checks = 0;
    int fails  = 0;
    logic [63:0] model_v;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vid_access u_vid_access (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_sel        (req_sel),
        .req_write      (req_write),
        .req_level      (req_level),
        .req_wdata      (req_wdata),
        .hyp_present    (hyp_present),
        .hyp_enabled    (hyp_enabled),
        .nv_ctrl        (nv_ctrl),
        .fgt_impl       (fgt_impl),
        .top_present    (top_present),
        .top_fgt_en     (top_fgt_en),
        .fgt_id_rd      (fgt_id_rd),
        .id_trap_feat   (id_trap_feat),
        .tge            (tge),
        .real_id        (REAL_VAL),
        .rsp_valid      (rsp_valid),
        .rsp_outcome    (rsp_outcome),
        .rsp_data       (rsp_data),
        .rsp_trap_level (rsp_trap_level),
        .rsp_syndrome   (rsp_syndrome),
        .rsp_mem_offset (rsp_mem_offset)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // Expected result from the requirements; updates model_v on a performed write.
    task automatic expect_of(output logic [5:0] oc, output logic [63:0] dat,
                             output logic [1:0] lvl, output string tag);
        dat = '0;
        lvl = 2'd0;
        if (req_sel) begin
            if (req_level == 2'd0) begin
                oc = E_UNDEF; tag = "R3";
            end else if (req_level == 2'd1) begin
                if (nv_ctrl[2] && nv_ctrl[0]) begin
                    oc = E_MEM; tag = "R4";
                end else if (nv_ctrl[0]) begin
                    oc = E_TRAP; lvl = 2'd2; tag = "R5";
                end else begin
                    oc = E_UNDEF; tag = "R5";
                end
            end else if (req_level == 2'd3 && !hyp_present) begin
                tag = "R7";
                if (req_write) oc = E_WIGN;
                else begin oc = E_DATA; dat = REAL_VAL; end
            end else begin
                tag = (req_level == 2'd2) ? "R6" : "R7";
                if (req_write) begin
                    oc = E_WDONE;
                    model_v = {32'h0, req_wdata[31:0]};
                end else begin
                    oc = E_DATA; dat = model_v;
                end
            end
        end else if (req_write) begin
            oc = E_UNDEF; tag = "R11";
        end else if (req_level == 2'd0) begin
            tag = "R10";
            if (!id_trap_feat) oc = E_UNDEF;
            else begin
                oc = E_TRAP;
                lvl = (hyp_enabled && tge) ? 2'd2 : 2'd1;
            end
        end else if (req_level == 2'd1) begin
            if (hyp_enabled && fgt_impl && fgt_id_rd && (top_fgt_en || !top_present)) begin
                oc = E_TRAP; lvl = 2'd2; tag = "R8";
            end else begin
                oc = E_DATA; tag = "R9";
                dat = hyp_enabled ? model_v : REAL_VAL;
            end
        end else begin
            oc = E_DATA; dat = REAL_VAL; tag = "R11";
        end
    endtask

    task automatic do_req();
        logic [5:0]  e_oc;
        logic [63:0] e_dat;
        logic [1:0]  e_lvl;
        string       tag;
        logic [89:0] got, exp;
        @(negedge clk);
        req_valid = 1'b1;
        expect_of(e_oc, e_dat, e_lvl, tag);
        @(negedge clk);
        req_valid = 1'b0;
        got = {rsp_valid, rsp_outcome, rsp_data, rsp_trap_level, rsp_syndrome, rsp_mem_offset};
        exp = {1'b1, e_oc, e_dat, e_lvl,
               (e_oc == E_TRAP) ? 6'h18 : 6'h00,
               (e_oc == E_MEM) ? 12'h088 : 12'h000};
        // R12 field zeroing is part of every comparison
        check({tag, "/R12"}, {38'h0, got[89:64]} ^ {38'h0, exp[89:64]} ^ 64'h0 | 64'h0, 64'h0);
        checks--;
        check({tag, "/R2"}, got[63:0] ^ exp[63:0] ^ {38'h0, got[89:64] ^ exp[89:64]}, 64'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int cnt;
        model_v = {32'h0, REAL_VAL[31:0]};
        repeat (3) @(negedge clk);
        // R1: no response while and right after reset
        check("R1", {63'h0, rsp_valid}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {58'h0, rsp_outcome}, 64'h0);
        // R1: reset value of the copy, upper bits cleared
        hyp_present = 1'b1; hyp_enabled = 1'b1;
        req_sel = 1'b1; req_write = 1'b0; req_level = 2'd2;
        do_req();
        // R2: strobe drops after one idle cycle
        @(negedge clk);
        check("R2", {63'h0, rsp_valid}, 64'h0);
        // R6: write then immediate read back
        req_write = 1'b1; req_wdata = 64'hFFFF_FFFF_1234_ABCD;
        do_req();
        req_write = 1'b0;
        do_req();
        // R7: ignored write at level 3 without hypervisor, seen later via level 2
        hyp_present = 1'b0; hyp_enabled = 1'b0; req_level = 2'd3;
        req_write = 1'b1; req_wdata = 64'h0;
        do_req();
        hyp_present = 1'b1; req_level = 2'd2; req_write = 1'b0;
        do_req();

        cnt = 0;
        for (int s = 0; s < 2; s++)
        for (int w = 0; w < 2; w++)
        for (int l = 0; l < 4; l++)
        for (int h = 0; h < 3; h++)
        for (int n = 0; n < 8; n++)
        for (int f = 0; f < 16; f++)
        for (int k = 0; k < 4; k++) begin
            if (!(h == 0 && l == 2)) begin
                req_sel      = s[0];
                req_write    = w[0];
                req_level    = l[1:0];
                hyp_present  = (h != 0);
                hyp_enabled  = (h == 2);
                nv_ctrl      = n[2:0];
                fgt_impl     = f[0];
                top_present  = f[1];
                top_fgt_en   = f[2];
                fgt_id_rd    = f[3];
                id_trap_feat = k[0];
                tge          = k[1];
                req_wdata    = {32'hC0DE_0000 ^ cnt, 32'h1357_9BDF + cnt * 32'h0101_0101};
                cnt++;
                do_req();
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule